// File: doc/BRIEF.md
# Shared Test-Port Controller with Boundary Scan and Serial Programming Shifter

This block owns four shared test pins: a clock, a mode/select line, a serial data input and a serial data output. A dedicated select input decides which function drives them. With select high, the pins form a standard IEEE 1149.1 test access port. That port has the full sixteen-state controller, a three-bit instruction register, a one-bit bypass register and a boundary register. With select low, the same pins feed a plain serial shift register. A programming sequencer elsewhere on the chip reads that register in parallel.

The boundary register gives each three-state user pin three cells: pad input, output data and output enable. Each input-only pin gets one cell. Under EXTEST, the update cells drive the user pads. Under any other instruction the pads follow the core logic. When the select pin falls, the controller raises a programming-mode flag. While that flag is set, every user pad is forced to high impedance. The flag clears once select returns high.

A single active-low reset serves both sides. It puts the test port into Test-Logic-Reset and clears the serial shifter and the programming flag.

Top module: `tap_isp_port`

## Requirements
- R1: With select high, five consecutive rising clock edges with mode high bring the controller to Test-Logic-Reset from any state. That state reloads the BYPASS instruction, so the pads return to core control.
- R2: Driving trst_n low resets the controller at once, without a clock edge. The instruction returns to BYPASS and the update cells clear, so pad_out and pad_oe follow core_out and core_oe.
- R3: In Capture-IR the instruction shift register loads 001. Those bits leave TDO least significant bit first: 1, then 0, then 0.
- R4: The instruction codes are EXTEST = 000, SAMPLE = 010 and BYPASS = 111. Every other code also selects the one-bit bypass register. That register captures 0 and delays TDI by one shift.
- R5: The boundary register is 3*N_TRI + N_IN cells long. Cell 3i holds pad_in[i], cell 3i+1 holds core_out[i], cell 3i+2 holds core_oe[i], and cell 3*N_TRI+j holds pin_in[j]. SAMPLE and EXTEST capture these values in Capture-DR. The register shifts out from cell 0 first, and TDI enters at the highest cell.
- R6: Under EXTEST, pad_out[i] is update cell 3i+1 and pad_oe[i] is update cell 3i+2. The update cells load on the falling clock edge in Update-DR, under both SAMPLE and EXTEST, so SAMPLE can preload them. Under any other instruction, the pads follow core_out and core_oe.
- R7: TDO changes on the falling clock edge. In test-port mode, tdo_oe is high only for the falling-edge periods that begin in Shift-IR or Shift-DR.
- R8: With select low, each rising clock edge with mode low shifts isp_word one place toward bit 0, taking serial data into the top bit. With mode high the register holds. TDO shows isp_word[0] and is always enabled.
- R9: A rising clock edge that sees select low, after it was high at the previous rising edge, sets prog_mode. While prog_mode is set, pad_oe is all zero. The first rising edge with select high clears it.
- R10: While select is low, the controller is held in Test-Logic-Reset. After a return to test-port mode the active instruction is BYPASS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Shared test / serial shift clock |
| trst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | High: test access port; low: serial programming shifter |
| tms_mode | input | 1 | Test mode select, or hold control of the shifter |
| tdi_sdi | input | 1 | Serial data input |
| tdo_sdo | output | 1 | Serial data output |
| tdo_oe | output | 1 | Drive enable for the serial output pin |
| prog_mode | output | 1 | Programming mode; forces user pads to high impedance |
| core_out | input | N_TRI | Core output data for the three-state pads |
| core_oe | input | N_TRI | Core output enables for the three-state pads |
| pad_in | input | N_TRI | Values read back from the three-state pads |
| pin_in | input | N_IN | Values at the input-only pins |
| pad_out | output | N_TRI | Data driven to the three-state pads |
| pad_oe | output | N_TRI | Enables driven to the three-state pads |
| isp_word | output | ISP_W | Parallel view of the programming shift register |

## Verification
Every test-port step is one rising edge. TDO for a shift bit is sampled 2 ns after the falling edge that follows entry into a shift state. Pad changes from Update-DR or Update-IR are due at the falling edge inside the update state, so they are checked after the next step that leaves to Run-Test/Idle. The shifter, prog_mode entry and prog_mode exit are rising-edge effects, checked 1 ns after the edge that causes them. The reset checks are made 1 ns after trst_n falls, with no clock edge in between.

// File: rtl/tap_isp_port.sv
module tap_isp_port #(
  parameter int N_TRI = 4,
  parameter int N_IN  = 2,
  parameter int ISP_W = 8
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             sel,
  input  logic             tms_mode,
  input  logic             tdi_sdi,
  output logic             tdo_sdo,
  output logic             tdo_oe,
  output logic             prog_mode,
  input  logic [N_TRI-1:0] core_out,
  input  logic [N_TRI-1:0] core_oe,
  input  logic [N_TRI-1:0] pad_in,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_TRI-1:0] pad_out,
  output logic [N_TRI-1:0] pad_oe,
  output logic [ISP_W-1:0] isp_word
);

  localparam int BLEN = 3*N_TRI + N_IN;
  localparam logic [2:0] OP_EXTEST = 3'b000;
  localparam logic [2:0] OP_SAMPLE = 3'b010;
  localparam logic [2:0] OP_BYPASS = 3'b111;

  typedef enum logic [3:0] {
    TLR = 4'd0, RTI = 4'd1, SEL_DR = 4'd2, CAP_DR = 4'd3, SH_DR = 4'd4,
    EX1_DR = 4'd5, PA_DR = 4'd6, EX2_DR = 4'd7, UPD_DR = 4'd8,
    SEL_IR = 4'd9, CAP_IR = 4'd10, SH_IR = 4'd11, EX1_IR = 4'd12,
    PA_IR = 4'd13, EX2_IR = 4'd14, UPD_IR = 4'd15
  } st_t;

  st_t st, nx;
  logic [2:0]       ir, ir_sr;
  logic             byp, tdo_q, oe_q, sel_q, prog;
  logic [BLEN-1:0]  bsr, upd, cap;
  logic [ISP_W-1:0] isp_sr;
  logic [N_TRI-1:0] upd_out, upd_oe;

  wire tms = tms_mode;
  wire tdi = tdi_sdi;
  wire use_bsr = (ir == OP_EXTEST) || (ir == OP_SAMPLE);
  wire extest  = (ir == OP_EXTEST);

  always_comb begin
    case (st)
      TLR:     nx = tms ? TLR    : RTI;
      RTI:     nx = tms ? SEL_DR : RTI;
      SEL_DR:  nx = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nx = tms ? EX1_DR : SH_DR;
      SH_DR:   nx = tms ? EX1_DR : SH_DR;
      EX1_DR:  nx = tms ? UPD_DR : PA_DR;
      PA_DR:   nx = tms ? EX2_DR : PA_DR;
      EX2_DR:  nx = tms ? UPD_DR : SH_DR;
      UPD_DR:  nx = tms ? SEL_DR : RTI;
      SEL_IR:  nx = tms ? TLR    : CAP_IR;
      CAP_IR:  nx = tms ? EX1_IR : SH_IR;
      SH_IR:   nx = tms ? EX1_IR : SH_IR;
      EX1_IR:  nx = tms ? UPD_IR : PA_IR;
      PA_IR:   nx = tms ? EX2_IR : PA_IR;
      EX2_IR:  nx = tms ? UPD_IR : SH_IR;
      UPD_IR:  nx = tms ? SEL_DR : RTI;
      default: nx = TLR;
    endcase
    if (!sel) nx = TLR;
  end

  always_comb begin
    cap = '0;
    for (int i = 0; i < N_TRI; i++) begin
      cap[3*i]   = pad_in[i];
      cap[3*i+1] = core_out[i];
      cap[3*i+2] = core_oe[i];
    end
    for (int j = 0; j < N_IN; j++) cap[3*N_TRI+j] = pin_in[j];
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      st     <= TLR;
      ir_sr  <= '0;
      byp    <= 1'b0;
      bsr    <= '0;
      sel_q  <= 1'b0;
      prog   <= 1'b0;
      isp_sr <= '0;
    end else begin
      st    <= nx;
      sel_q <= sel;
      if (sel) prog <= 1'b0;
      else if (sel_q) prog <= 1'b1;
      if (!sel && !tms) isp_sr <= {tdi, isp_sr[ISP_W-1:1]};
      if (st == CAP_IR) ir_sr <= 3'b001;
      else if (st == SH_IR) ir_sr <= {tdi, ir_sr[2:1]};
      if (st == CAP_DR) begin
        byp <= 1'b0;
        if (use_bsr) bsr <= cap;
      end else if (st == SH_DR) begin
        byp <= tdi;
        if (use_bsr) bsr <= {tdi, bsr[BLEN-1:1]};
      end
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir    <= OP_BYPASS;
      upd   <= '0;
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= (st == SH_IR) || (st == SH_DR);
      if (st == SH_IR) tdo_q <= ir_sr[0];
      else if (st == SH_DR) tdo_q <= use_bsr ? bsr[0] : byp;
      if (st == TLR) ir <= OP_BYPASS;
      else if (st == UPD_IR) ir <= ir_sr;
      if (st == UPD_DR && use_bsr) upd <= bsr;
    end
  end

  for (genvar g = 0; g < N_TRI; g++) begin : g_cell
    assign upd_out[g] = upd[3*g+1];
    assign upd_oe[g]  = upd[3*g+2];
  end

  assign pad_out   = extest ? upd_out : core_out;
  assign pad_oe    = prog ? '0 : (extest ? upd_oe : core_oe);
  assign prog_mode = prog;
  assign tdo_sdo   = sel ? tdo_q : isp_sr[0];
  assign tdo_oe    = sel ? oe_q : 1'b1;
  assign isp_word  = isp_sr;

endmodule

// File: rtl/tap_isp_port_chk.sv
module tap_isp_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       tdo_oe,
  input logic       prog_mode,
  input logic [3:0] st,
  input logic [2:0] ir_sr
);
  localparam logic [3:0] S_TLR = 4'd0, S_SH_DR = 4'd4, S_CAP_IR = 4'd10, S_SH_IR = 4'd11;

  AST_CAPTURE_IR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_CAP_IR |=> ir_sr == 3'b001); // R3

  AST_TDO_ONLY_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && tdo_oe) |-> (st == S_SH_DR || st == S_SH_IR)); // R7

  AST_PROG_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel) |=> prog_mode); // R9

  AST_PROG_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> !prog_mode); // R9

  AST_SEL_LOW_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> st == S_TLR); // R10
endmodule

bind tap_isp_port tap_isp_port_chk u_chk (
  .clk(tck), .rst_n(trst_n), .sel(sel), .tdo_oe(tdo_oe),
  .prog_mode(prog_mode), .st(st), .ir_sr(ir_sr)
);

// File: tb/tap_isp_port_tb.sv
module tap_isp_port_tb;
  localparam int NT = 4, NI = 2, IW = 8, BL = 3*NT + NI;

  logic tck = 1'b0;
  always #5 tck = ~tck;

  logic trst_n, sel, tms, tdi;
  logic [NT-1:0] core_out, core_oe, pad_in;
  logic [NI-1:0] pin_in;
  logic tdo_sdo, tdo_oe, prog_mode;
  logic [NT-1:0] pad_out, pad_oe;
  logic [IW-1:0] isp_word;
  int checks = 0, failures = 0;
  logic oe_in_shift;

  tap_isp_port #(.N_TRI(NT), .N_IN(NI), .ISP_W(IW)) u_dut (
    .tck(tck), .trst_n(trst_n), .sel(sel), .tms_mode(tms), .tdi_sdi(tdi),
    .tdo_sdo(tdo_sdo), .tdo_oe(tdo_oe), .prog_mode(prog_mode),
    .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .isp_word(isp_word)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tap(input logic t, input logic d, output logic o);
    @(negedge tck);
    #2;
    o = tdo_sdo;
    tms = t;
    tdi = d;
  endtask

  task automatic scan(input bit ir_path, input int n, input logic [31:0] vin, output logic [31:0] vout);
    logic o;
    vout = '0;
    tap(1'b1, 1'b0, o);
    if (ir_path) tap(1'b1, 1'b0, o);
    tap(1'b0, 1'b0, o);
    tap(1'b0, 1'b0, o);
    for (int k = 0; k < n; k++) begin
      tap(k == n-1, vin[k], o);
      vout[k] = o;
      if (k == 0) oe_in_shift = tdo_oe;
    end
    tap(1'b1, 1'b0, o);
    tap(1'b0, 1'b0, o);
  endtask

  function automatic logic [31:0] sample_exp();
    logic [31:0] v = '0;
    for (int i = 0; i < NT; i++) begin
      v[3*i] = pad_in[i];
      v[3*i+1] = core_out[i];
      v[3*i+2] = core_oe[i];
    end
    for (int j = 0; j < NI; j++) v[3*NT+j] = pin_in[j];
    return v;
  endfunction

  function automatic logic [31:0] drive_vec(input logic [NT-1:0] outs, input logic [NT-1:0] oes);
    logic [31:0] v = '0;
    for (int i = 0; i < NT; i++) begin
      v[3*i+1] = outs[i];
      v[3*i+2] = oes[i];
    end
    return v;
  endfunction

  task automatic t_reset();
    logic o;
    trst_n = 1'b0; sel = 1'b1; tms = 1'b1; tdi = 1'b0;
    repeat (3) @(negedge tck);
    #1;
    chk("R2", "reset pad_out", {28'd0, pad_out}, {28'd0, core_out});
    chk("R2", "reset pad_oe", {28'd0, pad_oe}, {28'd0, core_oe});
    chk("R9", "reset prog_mode", {31'd0, prog_mode}, 32'd0);
    chk("R7", "reset tdo_oe", {31'd0, tdo_oe}, 32'd0);
    trst_n = 1'b1;
    tap(1'b0, 1'b0, o);
  endtask

  task automatic t_ir_capture();
    logic [31:0] vo;
    scan(1'b1, 3, 32'h7, vo);
    chk("R3", "captured IR bits", vo & 32'h7, 32'h1);
    chk("R7", "tdo_oe in Shift-IR", {31'd0, oe_in_shift}, 32'd1);
    chk("R7", "tdo_oe in idle", {31'd0, tdo_oe}, 32'd0);
  endtask

  task automatic t_bypass();
    logic [31:0] vo;
    logic [31:0] vd;
    scan(1'b1, 3, 32'h5, vd);
    scan(1'b0, 4, 32'hD, vo);
    chk("R4", "unused code 101 bypass", vo & 32'hF, 32'hA);
    scan(1'b1, 3, 32'h7, vd);
    scan(1'b0, 4, 32'h6, vo);
    chk("R4", "code 111 bypass", vo & 32'hF, 32'hC);
    chk("R7", "tdo_oe in Shift-DR", {31'd0, oe_in_shift}, 32'd1);
  endtask

  task automatic t_sample();
    logic [31:0] vo, vd, pre;
    pre = drive_vec(4'b0101, 4'b1001);
    scan(1'b1, 3, 32'h2, vd);
    scan(1'b0, BL, pre, vo);
    chk("R5", "SAMPLE capture order", vo, sample_exp());
    chk("R6", "SAMPLE pads follow core", {28'd0, pad_out}, {28'd0, core_out});
    scan(1'b1, 3, 32'h0, vd);
    chk("R6", "EXTEST preload pad_out", {28'd0, pad_out}, 32'h5);
    chk("R6", "EXTEST preload pad_oe", {28'd0, pad_oe}, 32'h9);
  endtask

  task automatic t_extest();
    logic [31:0] vo;
    scan(1'b0, BL, drive_vec(4'b0011, 4'b1111), vo);
    chk("R5", "EXTEST capture", vo, sample_exp());
    chk("R6", "EXTEST pad_out", {28'd0, pad_out}, 32'h3);
    chk("R6", "EXTEST pad_oe", {28'd0, pad_oe}, 32'hF);
  endtask

  task automatic t_tlr_tms();
    logic o;
    tap(1'b1, 1'b0, o); tap(1'b0, 1'b0, o); tap(1'b0, 1'b0, o);
    repeat (5) tap(1'b1, 1'b0, o);
    tap(1'b0, 1'b0, o);
    chk("R1", "five TMS-high to reset, pad_out", {28'd0, pad_out}, {28'd0, core_out});
    chk("R1", "five TMS-high to reset, pad_oe", {28'd0, pad_oe}, {28'd0, core_oe});
  endtask

  task automatic t_trst();
    logic [31:0] vd;
    logic o;
    scan(1'b1, 3, 32'h0, vd);
    scan(1'b0, BL, drive_vec(4'b0011, 4'b1111), vd);
    chk("R6", "EXTEST reloaded", {28'd0, pad_out}, 32'h3);
    @(posedge tck); #2;
    trst_n = 1'b0;
    #1;
    chk("R2", "async reset pad_out", {28'd0, pad_out}, {28'd0, core_out});
    chk("R2", "async reset pad_oe", {28'd0, pad_oe}, {28'd0, core_oe});
    @(negedge tck); #1;
    trst_n = 1'b1;
    tap(1'b0, 1'b0, o);
  endtask

  task automatic t_isp();
    logic [31:0] vd;
    logic [IW-1:0] pat = 8'b1011_0010;
    logic o;
    core_oe = 4'b1111;
    scan(1'b1, 3, 32'h0, vd);
    scan(1'b0, BL, drive_vec(4'b0011, 4'b0111), vd);
    chk("R6", "EXTEST before ISP", {28'd0, pad_out}, 32'h3);
    @(negedge tck); #2;
    sel = 1'b0; tms = 1'b0; tdi = 1'b0;
    @(posedge tck); #1;
    chk("R9", "prog_mode on select fall", {31'd0, prog_mode}, 32'd1);
    chk("R9", "pads tri-stated", {28'd0, pad_oe}, 32'd0);
    for (int k = 0; k < IW; k++) tap(1'b0, pat[k], o);
    @(posedge tck); #1;
    chk("R8", "isp_word after shifts", {24'd0, isp_word}, {24'd0, pat});
    chk("R8", "tdo shows bit 0", {31'd0, tdo_sdo}, {31'd0, pat[0]});
    chk("R8", "tdo enabled", {31'd0, tdo_oe}, 32'd1);
    tap(1'b1, 1'b1, o);
    @(posedge tck); #1;
    chk("R8", "mode high holds", {24'd0, isp_word}, {24'd0, pat});
    chk("R9", "prog_mode held", {31'd0, prog_mode}, 32'd1);
    @(negedge tck); #2;
    sel = 1'b1;
    @(posedge tck); #1;
    chk("R9", "prog_mode cleared", {31'd0, prog_mode}, 32'd0);
    tap(1'b0, 1'b0, o);
    chk("R10", "BYPASS after ISP, pad_out", {28'd0, pad_out}, {28'd0, core_out});
    chk("R10", "BYPASS after ISP, pad_oe", {28'd0, pad_oe}, {28'd0, core_oe});
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    core_out = 4'b1010; core_oe = 4'b0110; pad_in = 4'b1100; pin_in = 2'b01;
    t_reset();
    t_ir_capture();
    t_bypass();
    t_sample();
    t_extest();
    t_tlr_tms();
    t_trst();
    t_isp();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule